// File: doc/BRIEF.md
# Stop-Mode Entry and Wake-Up Controller

This block sequences a small processor core into and out of its deepest low-power state. A register write carrying a stop request, a release-mode select, a warm-up length select, a memory power-down flag and per-key enable bits hands the block its configuration. The block captures that configuration, turns the oscillator enable off, and pulses a clear to the clock prescaler and the timing divider. It then waits for a release condition. A release sends it through a warm-up count of the restarted oscillator. When memory power-down was requested, a further settle period follows. Only after these does the core clock enable return.

Release comes either from a dedicated active-high release pin or from four key wake-up inputs, and both are brought in through two-flop synchronisers. The release-mode select picks how the pin and keys are read. In level mode, a high release pin or an enabled, active key releases the stop. In edge mode, only a rising edge of the release pin counts, and the keys are ignored. The block runs on an always-on clock. The state is reported on a 2-bit status output, and a single-cycle pulse marks the return to normal running.

Top module: `stopwake_ctrl`

## Requirements
- R1: During and directly after reset, the status is RUN (code 0), the oscillator enable and core clock enable are 1, and the divider clear and resume pulse are 0.
- R2: In RUN, a cycle with req_valid=1 and req_stop=1 moves the status to STOP (code 1) on the next edge, with osc_en=0 and core_clk_en=0; req_valid=1 with req_stop=0 leaves the status at RUN.
- R3: div_clr is high for exactly the first cycle of a STOP entered from RUN, and low otherwise.
- R4: With req_level=1 captured at entry, a high release pin or any key input whose captured enable bit is 1 moves STOP to WARMUP (code 2). The input is synchronised by two flops, so the status changes on the third rising edge after the input changes.
- R5: If req_level=1 and the synchronised release pin is already high when the request is accepted, the block goes straight to WARMUP. STOP is never shown, osc_en stays 1 and div_clr stays 0.
- R6: Key inputs never release STOP when req_level=0 was captured. In level mode, a key whose enable bit (bit i enables key_in[i]) is 0 is ignored.
- R7: With req_level=0 captured, only a 0-to-1 transition of the synchronised release pin releases STOP. A pin that is already high at entry, or that stays high, does not.
- R8: WARMUP lasts exactly 2^(WARM_BASE + WARM_STEP*sel) cycles, where sel is the 2-bit warm-up select captured at entry. During it osc_en=1 and core_clk_en=0.
- R9: If req_mempd=1 was captured, WARMUP is followed by MEMWAIT (code 3) lasting MEM_CYCLES cycles, then RUN. Otherwise WARMUP goes directly to RUN.
- R10: resume_pulse is high for exactly the first cycle back in RUN. core_clk_en is 0 in every state other than RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Control register write strobe |
| req_stop | input | 1 | Stop request bit of the write |
| req_level | input | 1 | Release mode: 1 level, 0 edge |
| req_mempd | input | 1 | Add memory-supply settle wait after warm-up |
| req_warm_sel | input | 2 | Warm-up length select |
| req_key_en | input | NKEY | Per-key wake-up enable bits |
| rel_pin | input | 1 | Asynchronous active-high release pin |
| key_in | input | NKEY | Asynchronous active-high key wake-up inputs |
| osc_en | output | 1 | Oscillator enable, 0 while stopped |
| core_clk_en | output | 1 | Core clock enable, 1 only in RUN |
| div_clr | output | 1 | One-cycle clear of prescaler and divider on stop entry |
| resume_pulse | output | 1 | One-cycle pulse on return to RUN |
| state_o | output | 2 | Status: 0 RUN, 1 STOP, 2 WARMUP, 3 MEMWAIT |

## Verification
The bench sweeps every combination of release mode, memory flag and warm-up select, and measures the WARMUP and MEMWAIT lengths cycle by cycle. An off-by-one counter would show up as a length one cycle short or long. A design that lost the memory flag would skip MEMWAIT. Every key/enable pairing is tried in level mode, and all enabled keys are tried in edge mode. A design that ignored the enable mask, or that honoured keys in edge mode, would leave STOP when it must not. The bench also makes a level-mode request with the pin already high, which must bypass STOP, and an edge-mode request with the pin already high, which must hold in STOP until a fresh rising edge. A design that treated a level as an edge, or an edge as a level, fails one of the two.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

    typedef enum logic [1:0] {
        SW_RUN  = 2'd0,
        SW_STOP = 2'd1,
        SW_WARM = 2'd2,
        SW_MEMW = 2'd3
    } sw_state_e;

    typedef struct packed {
        logic       level;
        logic       mempd;
        logic [1:0] warm_sel;
    } sw_cfg_t;

    // Warm-up length as a power of two picked by the select field.
    function automatic int unsigned warm_log2(input int unsigned base,
                                              input int unsigned step,
                                              input logic [1:0] sel);
        return base + step * int'(sel);
    endfunction

endpackage

// File: rtl/stopwake_sync.sv
module stopwake_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/stopwake_wake.sv
module stopwake_wake #(
    parameter int NKEY = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rel_s,
    input  logic [NKEY-1:0] key_s,
    input  logic [NKEY-1:0] key_en,
    input  logic            level_mode,
    output logic            wake
);
    logic            rel_prev_q;
    logic            rel_rise;
    logic [NKEY-1:0] key_hit;

    always_ff @(posedge clk) begin
        if (rst) rel_prev_q <= 1'b0;
        else     rel_prev_q <= rel_s;
    end

    assign rel_rise = rel_s & ~rel_prev_q;

    // Keys count only when enabled and only in level mode.
    for (genvar i = 0; i < NKEY; i++) begin : g_key
        assign key_hit[i] = key_s[i] & key_en[i] & level_mode;
    end

    assign wake = level_mode ? (rel_s | (|key_hit)) : rel_rise;
endmodule

// File: rtl/stopwake_timer.sv
module stopwake_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else              cnt_q <= cnt_q + CNT_W'(1);
    end

    assign done = (cnt_q == (limit - CNT_W'(1)));
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
    import stopwake_pkg::*;
#(
    parameter int NKEY       = 4,
    parameter int WARM_BASE  = 8,
    parameter int WARM_STEP  = 2,
    parameter int MEM_CYCLES = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_stop,
    input  logic            req_level,
    input  logic            req_mempd,
    input  logic [1:0]      req_warm_sel,
    input  logic [NKEY-1:0] req_key_en,
    input  logic            rel_pin,
    input  logic [NKEY-1:0] key_in,
    output logic            osc_en,
    output logic            core_clk_en,
    output logic            div_clr,
    output logic            resume_pulse,
    output logic [1:0]      state_o
);
    localparam int MAX_WLOG = WARM_BASE + 3 * WARM_STEP;
    localparam int MEM_W    = $clog2(MEM_CYCLES + 1) + 1;
    localparam int CNT_W    = (MAX_WLOG + 1 > MEM_W) ? MAX_WLOG + 1 : MEM_W;

    sw_state_e       state_q, state_d;
    sw_cfg_t         cfg_q;
    logic [NKEY-1:0] key_en_q;
    logic            rel_s;
    logic [NKEY-1:0] key_s;
    logic            wake;
    logic            accept;
    logic            t_clear, t_done;
    logic [CNT_W-1:0] warm_lim, limit;
    logic            div_clr_q, resume_q;

    stopwake_sync #(.W(1)) u_rel_sync (
        .clk(clk), .rst(rst), .d(rel_pin), .q(rel_s)
    );

    stopwake_sync #(.W(NKEY)) u_key_sync (
        .clk(clk), .rst(rst), .d(key_in), .q(key_s)
    );

    stopwake_wake #(.NKEY(NKEY)) u_wake (
        .clk(clk), .rst(rst), .rel_s(rel_s), .key_s(key_s),
        .key_en(key_en_q), .level_mode(cfg_q.level), .wake(wake)
    );

    assign warm_lim = CNT_W'(1) << warm_log2(WARM_BASE, WARM_STEP, cfg_q.warm_sel);
    assign limit    = (state_q == SW_MEMW) ? CNT_W'(MEM_CYCLES) : warm_lim;
    assign t_clear  = (state_q != state_d) ||
                      !(state_q == SW_WARM || state_q == SW_MEMW);

    stopwake_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .clear(t_clear), .limit(limit), .done(t_done)
    );

    assign accept = (state_q == SW_RUN) && req_valid && req_stop;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SW_RUN:  if (accept)
                         state_d = (req_level && rel_s) ? SW_WARM : SW_STOP;
            SW_STOP: if (wake)   state_d = SW_WARM;
            SW_WARM: if (t_done) state_d = cfg_q.mempd ? SW_MEMW : SW_RUN;
            SW_MEMW: if (t_done) state_d = SW_RUN;
            default:             state_d = SW_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SW_RUN;
            cfg_q     <= '0;
            key_en_q  <= '0;
            div_clr_q <= 1'b0;
            resume_q  <= 1'b0;
        end else begin
            state_q   <= state_d;
            div_clr_q <= (state_q == SW_RUN) && (state_d == SW_STOP);
            resume_q  <= (state_q != SW_RUN) && (state_d == SW_RUN);
            if (accept) begin
                cfg_q.level    <= req_level;
                cfg_q.mempd    <= req_mempd;
                cfg_q.warm_sel <= req_warm_sel;
                key_en_q       <= req_key_en;
            end
        end
    end

    assign osc_en       = (state_q != SW_STOP);
    assign core_clk_en  = (state_q == SW_RUN);
    assign div_clr      = div_clr_q;
    assign resume_pulse = resume_q;
    assign state_o      = state_q;
endmodule

// File: rtl/stopwake_chk.sv
module stopwake_chk
    import stopwake_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_stop,
    input logic       osc_en,
    input logic       core_clk_en,
    input logic       div_clr,
    input logic       resume_pulse,
    input logic [1:0] state
);
    a_r2_enter: assert property (@(posedge clk) disable iff (rst)
        (state == SW_RUN && req_valid && req_stop) |=>
            (state == SW_STOP || state == SW_WARM));

    a_r2_no_request: assert property (@(posedge clk) disable iff (rst)
        (state == SW_RUN && !(req_valid && req_stop)) |=> (state == SW_RUN));

    a_r3_clear_on_entry: assert property (@(posedge clk) disable iff (rst)
        div_clr |-> (state == SW_STOP && $past(state) == SW_RUN));

    a_r3_clear_single: assert property (@(posedge clk) disable iff (rst)
        div_clr |=> !div_clr);

    a_r8_warm_source: assert property (@(posedge clk) disable iff (rst)
        (state == SW_WARM && $past(state) != SW_WARM) |->
            ($past(state) == SW_STOP || $past(state) == SW_RUN));

    a_r8_osc_in_warm: assert property (@(posedge clk) disable iff (rst)
        (state == SW_WARM) |-> (osc_en && !core_clk_en));

    a_r9_mem_after_warm: assert property (@(posedge clk) disable iff (rst)
        (state == SW_MEMW && $past(state) != SW_MEMW) |-> ($past(state) == SW_WARM));

    a_r10_resume_first: assert property (@(posedge clk) disable iff (rst)
        resume_pulse |-> (state == SW_RUN && $past(state) != SW_RUN && core_clk_en));

    a_r10_resume_single: assert property (@(posedge clk) disable iff (rst)
        resume_pulse |=> !resume_pulse);
endmodule

bind stopwake_ctrl stopwake_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_stop(req_stop),
    .osc_en(osc_en), .core_clk_en(core_clk_en), .div_clr(div_clr),
    .resume_pulse(resume_pulse), .state(state_o)
);

// File: tb/sim_stopwake_ctrl.sv
module sim_stopwake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NK = 4;
    localparam int WB = 2;
    localparam int WS = 1;
    localparam int MEMC = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_stop = 1'b0, req_level = 1'b0, req_mempd = 1'b0;
    logic [1:0] req_warm_sel = '0;
    logic [NK-1:0] req_key_en = '0;
    logic rel_pin = 1'b0;
    logic [NK-1:0] key_in = '0;
    logic osc_en, core_clk_en, div_clr, resume_pulse;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    stopwake_ctrl #(.NKEY(NK), .WARM_BASE(WB), .WARM_STEP(WS), .MEM_CYCLES(MEMC)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_stop(req_stop),
        .req_level(req_level), .req_mempd(req_mempd), .req_warm_sel(req_warm_sel),
        .req_key_en(req_key_en), .rel_pin(rel_pin), .key_in(key_in),
        .osc_en(osc_en), .core_clk_en(core_clk_en), .div_clr(div_clr),
        .resume_pulse(resume_pulse), .state_o(state_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter(input bit lvl, input bit mem, input int sel, input logic [NK-1:0] ken);
        req_valid = 1'b1; req_stop = 1'b1; req_level = lvl; req_mempd = mem;
        req_warm_sel = 2'(sel); req_key_en = ken;
        @(negedge clk);
        req_valid = 1'b0; req_stop = 1'b0;
    endtask

    // Called with the status just sampled as WARMUP.
    task automatic run_out(input bit mem, input int sel);
        int n = 0;
        int m = 0;
        chk("R8 osc_en in warm-up", osc_en, 1);
        chk("R10 core clock off in warm-up", core_clk_en, 0);
        while (state_o == 2 && n < 5000) begin n++; @(negedge clk); end
        chk("R8 warm-up length", n, 1 << (WB + WS * sel));
        if (mem) begin
            chk("R9 memwait follows", state_o, 3);
            chk("R10 core clock off in memwait", core_clk_en, 0);
            while (state_o == 3 && m < 5000) begin m++; @(negedge clk); end
            chk("R9 memwait length", m, MEMC);
        end
        chk("R9 back to run", state_o, 0);
        chk("R10 resume pulse", resume_pulse, 1);
        chk("R10 core clock on", core_clk_en, 1);
        @(negedge clk);
        chk("R10 resume single", resume_pulse, 0);
    endtask

    initial begin
        idle(4);
        chk("R1 state", state_o, 0);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 core_clk_en", core_clk_en, 1);
        chk("R1 div_clr", div_clr, 0);
        chk("R1 resume", resume_pulse, 0);
        rst = 1'b0;
        idle(2);
        chk("R1 after reset", state_o, 0);

        // R2: write without stop bit
        req_valid = 1'b1; req_stop = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        idle(3);
        chk("R2 no stop bit state", state_o, 0);
        chk("R2 no stop bit osc", osc_en, 1);

        // Sweep of mode, memory flag and warm-up select, released by the pin.
        for (int lvl = 0; lvl < 2; lvl++) begin
            for (int mem = 0; mem < 2; mem++) begin
                for (int sel = 0; sel < 4; sel++) begin
                    rel_pin = 1'b0; key_in = '0;
                    idle(4);
                    enter(lvl[0], mem[0], sel, '0);
                    chk("R2 stop entered", state_o, 1);
                    chk("R2 osc off", osc_en, 0);
                    chk("R10 core clock off in stop", core_clk_en, 0);
                    chk("R3 clear pulse", div_clr, 1);
                    @(negedge clk);
                    chk("R3 clear single", div_clr, 0);
                    rel_pin = 1'b1;
                    idle(2);
                    chk(lvl ? "R4 sync delay" : "R7 sync delay", state_o, 1);
                    @(negedge clk);
                    chk(lvl ? "R4 pin release" : "R7 edge release", state_o, 2);
                    run_out(mem[0], sel);
                    rel_pin = 1'b0;
                end
            end
        end

        // R5: level-mode request with pin already high
        rel_pin = 1'b1;
        idle(4);
        enter(1'b1, 1'b0, 0, '0);
        chk("R5 straight to warm-up", state_o, 2);
        chk("R5 osc stays on", osc_en, 1);
        chk("R5 no clear", div_clr, 0);
        run_out(1'b0, 0);
        rel_pin = 1'b0;

        // R7: edge-mode request with pin already high
        rel_pin = 1'b1;
        idle(4);
        enter(1'b0, 1'b0, 1, '0);
        chk("R7 enters stop with pin high", state_o, 1);
        idle(8);
        chk("R7 high level ignored", state_o, 1);
        rel_pin = 1'b0;
        idle(5);
        chk("R7 falling ignored", state_o, 1);
        rel_pin = 1'b1;
        idle(2);
        chk("R7 sync delay", state_o, 1);
        @(negedge clk);
        chk("R7 rising edge releases", state_o, 2);
        run_out(1'b0, 1);
        rel_pin = 1'b0;

        // R4/R6: every key against every single-key enable, level mode
        for (int i = 0; i < NK; i++) begin
            for (int j = 0; j < NK; j++) begin
                rel_pin = 1'b0; key_in = '0;
                idle(4);
                enter(1'b1, 1'b0, 0, NK'(1) << i);
                key_in = NK'(1) << j;
                idle(2);
                chk("R4 key sync delay", state_o, 1);
                @(negedge clk);
                if (i == j) begin
                    chk("R4 enabled key releases", state_o, 2);
                end else begin
                    idle(5);
                    chk("R6 disabled key ignored", state_o, 1);
                    key_in = '0;
                    rel_pin = 1'b1;
                    idle(3);
                    chk("R4 pin release after key", state_o, 2);
                end
                run_out(1'b0, 0);
                key_in = '0; rel_pin = 1'b0;
            end
        end

        // R6: keys ignored in edge mode even when enabled
        idle(4);
        enter(1'b0, 1'b0, 0, '1);
        key_in = '1;
        idle(10);
        chk("R6 keys ignored in edge mode", state_o, 1);
        chk("R6 osc still off", osc_en, 0);
        key_in = '0;
        rel_pin = 1'b1;
        idle(3);
        chk("R7 edge release after keys", state_o, 2);
        run_out(1'b0, 0);
        rel_pin = 1'b0;

        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule